// File: doc/BRIEF.md
# Multichannel Serial Sample Deserializer

This block recovers parallel converter samples from serial lanes. Every channel carries its sample bit by bit on one lane (one-wire mode) or split over two lanes (two-wire mode). All channels share one double-data-rate bit clock and one frame clock. The frame clock runs at the sample rate, and its rising transition marks where each sample word starts. A bit is taken from every lane on both edges of the bit clock. For each frame, every channel yields one right-justified word of 12, 14 or 16 bits, and all channels share one valid strobe. The block covers edge capture, frame alignment and word assembly. Pad cells, clock delay trimming and output buffering are outside it.

Inside, a DDR capture stage hands each rising edge a pair of bit slots: the slot captured on the preceding falling edge, then the slot captured on the rising edge. A frame tracker steps through both slots in one cycle. Its states are SEEK (no frame boundary seen since reset or since a configuration change), FILL (counting the bits of a word) and HOLD (word emitted, waiting for the next boundary). Its transitions are:
- lock: SEEK to FILL on a boundary.
- complete: FILL to HOLD when the count reaches the bits-per-lane value.
- rearm: HOLD to FILL on the next boundary.
- restart: FILL to FILL on a boundary that arrives early, which drops the partial word.
- reconfigure: any state to SEEK when the mode or resolution input changes.

Per-channel shift windows supply the last bits of each lane when a word completes.

Top module: `lvds_serial_deser`

## Requirements
- R1: In one-wire mode, each channel's word is the last N bits seen on its first lane, most significant bit first. N is 12 for `res_sel`=0, 14 for 1, and 16 for both 2 and 3.
- R2: In two-wire mode (`two_wire`=1), each lane carries N/2 bits per frame. The first lane carries word bits N-2, N-4, ..., 0 and the second lane carries bits N-1, N-3, ..., 1, both starting with their highest bit.
- R3: A bit is taken from every lane on both the falling and the rising edge of `bclk`. Consecutive edges carry consecutive bits of the stream.
- R4: The frame boundary is the edge on which `frame_in` is sampled high after being sampled low on the previous edge. The bit on that edge is the first bit of the word. Bits before the first boundary contribute to no word.
- R5: `word_valid` pulses for one cycle per completed frame and covers all channels at once. Channel c occupies `word_out[16c+15:16c]`, and the bits at or above N are zero.
- R6: While reset is asserted, `word_valid` and `word_out` are zero. No word appears until a boundary is seen after reset. A `frame_in` that is already high when reset is released does not count as a boundary.
- R7: A boundary that arrives before the current word has its N (or N/2) bits discards the partial word. The next word is recovered intact.
- R8: In one-wire mode, the values on `lane_b` have no effect on `word_out`.
- R9: A change of `two_wire` or `res_sel` abandons any word in progress. No word is produced until a new boundary arrives under the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | DDR bit clock; data and frame are taken on both edges |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_in | input | 1 | Frame clock at the sample rate, shared by all channels |
| lane_a | input | N_CH | First serial lane of each channel |
| lane_b | input | N_CH | Second serial lane of each channel (two-wire mode only) |
| two_wire | input | 1 | 0: one lane per channel, 1: two lanes per channel |
| res_sel | input | 2 | Sample width: 0=12, 1=14, 2 or 3=16 bits |
| word_out | output | N_CH*16 | Recovered words, channel 0 in the low slice |
| word_valid | output | 1 | One-cycle strobe when `word_out` holds a new frame |

## Verification
The assertions assume that `two_wire` and `res_sel` stay fixed around each word completion, so the zero check on the upper bits can use the current width. They also assume that frames are at least six bit-edges long, so that completions are always three or more cycles apart. The stimulus changes the configuration only after idle edges, or in the middle of a frame that is meant to be dropped. It builds every frame from the selected width, with the frame clock high for the first half of the frame's edges. Lanes and frame are driven one nanosecond after each bit-clock edge, so each value is settled before the edge that captures it.

// File: rtl/lvds_deser_pkg.sv
package lvds_deser_pkg;

    localparam int MAX_RES = 16;
    localparam int CNT_W   = $clog2(MAX_RES + 1);

    typedef logic [CNT_W-1:0] bit_cnt_t;

    typedef enum logic [1:0] {
        ST_SEEK = 2'd0,
        ST_FILL = 2'd1,
        ST_HOLD = 2'd2
    } trk_state_e;

    typedef struct packed {
        logic       two_wire;
        logic [1:0] res_sel;
    } deser_cfg_t;

    typedef struct packed {
        trk_state_e st;
        bit_cnt_t   cnt;
        logic       done;
    } trk_step_t;

    // Sample width selected by the resolution code.
    function automatic bit_cnt_t res_bits(input logic [1:0] sel);
        bit_cnt_t r;
        unique case (sel)
            2'd0:    r = bit_cnt_t'(12);
            2'd1:    r = bit_cnt_t'(14);
            default: r = bit_cnt_t'(16);
        endcase
        return r;
    endfunction

    // Bits carried by one lane in one frame.
    function automatic bit_cnt_t lane_bits(input deser_cfg_t c);
        bit_cnt_t r;
        r = res_bits(c.res_sel);
        return c.two_wire ? (r >> 1) : r;
    endfunction

    // Mask with the low n bits set.
    function automatic logic [MAX_RES-1:0] low_mask(input bit_cnt_t n);
        logic [MAX_RES-1:0] m;
        for (int i = 0; i < MAX_RES; i++) begin
            m[i] = (i < int'(n));
        end
        return m;
    endfunction

    // One bit-edge step of the frame tracker.
    function automatic trk_step_t trk_step(input trk_state_e st,
                                           input bit_cnt_t   cnt,
                                           input logic       rise,
                                           input bit_cnt_t   blen);
        trk_step_t o;
        bit_cnt_t  inc;
        inc    = cnt + 1'b1;
        o.st   = st;
        o.cnt  = cnt;
        o.done = 1'b0;
        if (rise) begin
            o.st  = ST_FILL;
            o.cnt = bit_cnt_t'(1);
        end else begin
            unique case (st)
                ST_SEEK: begin
                    o.st = ST_SEEK;
                end
                ST_FILL: begin
                    o.cnt = inc;
                    if (inc == blen) begin
                        o.done = 1'b1;
                        o.st   = ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    o.st = ST_HOLD;
                end
                default: begin
                    o.st  = ST_SEEK;
                    o.cnt = '0;
                end
            endcase
        end
        return o;
    endfunction

endpackage

// File: rtl/lvds_ddr_capture.sv
module lvds_ddr_capture #(
    parameter int               LANES   = 1,
    parameter logic [LANES-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] early,
    output logic [LANES-1:0] late
);

    logic [LANES-1:0] fall_q;

    // Slot taken on the falling edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= RST_VAL;
        end else begin
            fall_q <= din;
        end
    end

    // Rising edge presents the pair: falling slot first, rising slot second.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            early <= RST_VAL;
            late  <= RST_VAL;
        end else begin
            early <= fall_q;
            late  <= din;
        end
    end

endmodule

// File: rtl/lvds_frame_tracker.sv
module lvds_frame_tracker
    import lvds_deser_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  deser_cfg_t cfg_in,
    input  logic       fr_early,
    input  logic       fr_late,
    output deser_cfg_t cfg_act,
    output trk_state_e state,
    output logic       done_early,
    output logic       done_late
);

    trk_state_e st_q,  st_d;
    bit_cnt_t   cnt_q, cnt_d;
    logic       fprev_q;
    deser_cfg_t cfg_q;

    bit_cnt_t   blen;
    logic       rise_e, rise_l, reconf;
    trk_step_t  step_e, step_l;

    // Next-state logic: walk both bit slots of the pair in order.
    always_comb begin
        blen   = lane_bits(cfg_q);
        rise_e = fr_early & ~fprev_q;
        rise_l = fr_late  & ~fr_early;
        reconf = (cfg_in != cfg_q);
        step_e = trk_step(st_q, cnt_q, rise_e, blen);
        step_l = trk_step(step_e.st, step_e.cnt, rise_l, blen);
        if (reconf) begin
            st_d  = ST_SEEK;
            cnt_d = '0;
        end else begin
            st_d  = step_l.st;
            cnt_d = step_l.cnt;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_SEEK;
            cnt_q   <= '0;
            fprev_q <= 1'b1;
            cfg_q   <= '0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            fprev_q <= fr_late;
            cfg_q   <= cfg_in;
        end
    end

    // Outputs.
    always_comb begin
        state      = st_q;
        cfg_act    = cfg_q;
        done_early = step_e.done & ~reconf;
        done_late  = step_l.done & ~reconf;
    end

endmodule

// File: rtl/lvds_word_assembler.sv
module lvds_word_assembler
    import lvds_deser_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  deser_cfg_t                cfg,
    input  logic [N_CH-1:0]           a_early,
    input  logic [N_CH-1:0]           a_late,
    input  logic [N_CH-1:0]           b_early,
    input  logic [N_CH-1:0]           b_late,
    input  logic                      done_early,
    input  logic                      done_late,
    output logic [N_CH*MAX_RES-1:0]   words,
    output logic                      valid
);

    localparam int WORD_W = MAX_RES;
    localparam int HALF_W = WORD_W / 2;

    bit_cnt_t           res, half;
    logic [WORD_W-1:0]  rmask;
    logic [HALF_W-1:0]  hmask;
    logic               take;

    always_comb begin
        res   = res_bits(cfg.res_sel);
        half  = res >> 1;
        rmask = low_mask(res);
        for (int i = 0; i < HALF_W; i++) begin
            hmask[i] = (i < int'(half));
        end
        take = done_early | done_late;
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic [WORD_W-1:0] sha_q, wa0, wa1, wa;
        logic [HALF_W-1:0] shb_q, wb0, wb1, wb;
        logic [WORD_W-1:0] word_d, word_q;

        assign wa0 = {sha_q[WORD_W-2:0], a_early[ch]};
        assign wa1 = {sha_q[WORD_W-3:0], a_early[ch], a_late[ch]};
        assign wb0 = {shb_q[HALF_W-2:0], b_early[ch]};
        assign wb1 = {shb_q[HALF_W-3:0], b_early[ch], b_late[ch]};

        always_comb begin
            wa = done_early ? wa0 : wa1;
            wb = done_early ? wb0 : wb1;
            if (cfg.two_wire) begin
                word_d = '0;
                for (int i = 0; i < HALF_W; i++) begin
                    word_d[2*i]   = wa[i] & hmask[i];
                    word_d[2*i+1] = wb[i] & hmask[i];
                end
            end else begin
                word_d = wa & rmask;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sha_q  <= '0;
                shb_q  <= '0;
                word_q <= '0;
            end else begin
                sha_q <= wa1;
                shb_q <= wb1;
                if (take) begin
                    word_q <= word_d;
                end
            end
        end

        assign words[ch*WORD_W +: WORD_W] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else begin
            valid <= take;
        end
    end

endmodule

// File: rtl/lvds_serial_deser.sv
module lvds_serial_deser
    import lvds_deser_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic                    bclk,
    input  logic                    rst_n,
    input  logic                    frame_in,
    input  logic [N_CH-1:0]         lane_a,
    input  logic [N_CH-1:0]         lane_b,
    input  logic                    two_wire,
    input  logic [1:0]              res_sel,
    output logic [N_CH*MAX_RES-1:0] word_out,
    output logic                    word_valid
);

    localparam int               CAP_W   = 2 * N_CH + 1;
    localparam logic [CAP_W-1:0] CAP_RST = {1'b1, {(2*N_CH){1'b0}}};

    deser_cfg_t       cfg_in, cfg_act;
    trk_state_e       trk_st;
    logic [CAP_W-1:0] cap_early, cap_late;
    logic             done_early, done_late;

    assign cfg_in = {two_wire, res_sel};

    lvds_ddr_capture #(
        .LANES   (CAP_W),
        .RST_VAL (CAP_RST)
    ) u_cap (
        .clk   (bclk),
        .rst_n (rst_n),
        .din   ({frame_in, lane_b, lane_a}),
        .early (cap_early),
        .late  (cap_late)
    );

    lvds_frame_tracker u_trk (
        .clk        (bclk),
        .rst_n      (rst_n),
        .cfg_in     (cfg_in),
        .fr_early   (cap_early[CAP_W-1]),
        .fr_late    (cap_late[CAP_W-1]),
        .cfg_act    (cfg_act),
        .state      (trk_st),
        .done_early (done_early),
        .done_late  (done_late)
    );

    lvds_word_assembler #(
        .N_CH (N_CH)
    ) u_asm (
        .clk        (bclk),
        .rst_n      (rst_n),
        .cfg        (cfg_act),
        .a_early    (cap_early[N_CH-1:0]),
        .a_late     (cap_late[N_CH-1:0]),
        .b_early    (cap_early[2*N_CH-1:N_CH]),
        .b_late     (cap_late[2*N_CH-1:N_CH]),
        .done_early (done_early),
        .done_late  (done_late),
        .words      (word_out),
        .valid      (word_valid)
    );

endmodule

// File: rtl/lvds_serial_deser_checker.sv
module lvds_serial_deser_checker
    import lvds_deser_pkg::*;
#(
    parameter int N_CH = 4
) (
    input logic                    bclk,
    input logic                    rst_n,
    input logic                    two_wire,
    input logic [1:0]              res_sel,
    input logic [N_CH*MAX_RES-1:0] word_out,
    input logic                    word_valid,
    input trk_state_e              trk_state
);

    logic [MAX_RES-1:0] keep_mask;
    assign keep_mask = low_mask(res_bits(res_sel));

    // R5: a word strobe never follows another within two cycles
    p_single_pulse_r5: assert property (@(posedge bclk) disable iff (!rst_n)
        word_valid |-> (!$past(word_valid) && !$past(word_valid, 2)));

    // R6: a tracker still seeking a boundary yields no word next cycle
    p_seek_quiet_r6: assert property (@(posedge bclk) disable iff (!rst_n)
        (trk_state == ST_SEEK) |=> !word_valid);

    // R9: a configuration change sends the tracker back to seeking
    p_cfg_reseek_r9: assert property (@(posedge bclk) disable iff (!rst_n)
        ({two_wire, res_sel} != $past({two_wire, res_sel})) |=> (trk_state == ST_SEEK));

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chk
        // R5: bits at or above the sample width stay zero
        p_upper_zero_r5: assert property (@(posedge bclk) disable iff (!rst_n)
            word_valid |-> ((word_out[ch*MAX_RES +: MAX_RES] & ~keep_mask) == '0));
    end

endmodule

bind lvds_serial_deser lvds_serial_deser_checker #(.N_CH(N_CH)) u_chk (
    .bclk       (bclk),
    .rst_n      (rst_n),
    .two_wire   (two_wire),
    .res_sel    (res_sel),
    .word_out   (word_out),
    .word_valid (word_valid),
    .trk_state  (trk_st)
);

// File: tb/lvds_serial_deser_test.sv
module lvds_serial_deser_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N  = 4;
    localparam int W  = 16;
    localparam int NF = 5;
    localparam int NT = 7;

    // {two_wire, res_sel, expected sample width}
    localparam logic [7:0] CFG_TBL [NT] = '{
        {1'b0, 2'd0, 5'd12},
        {1'b0, 2'd1, 5'd14},
        {1'b0, 2'd2, 5'd16},
        {1'b0, 2'd3, 5'd16},
        {1'b1, 2'd0, 5'd12},
        {1'b1, 2'd1, 5'd14},
        {1'b1, 2'd2, 5'd16}
    };

    logic           bclk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_in = 1'b1;
    logic [N-1:0]   lane_a = '0;
    logic [N-1:0]   lane_b = '0;
    logic           two_wire = 1'b0;
    logic [1:0]     res_sel = 2'd0;
    logic [N*W-1:0] word_out;
    logic           word_valid;

    int    checks = 0;
    int    errors = 0;
    int    nvalid = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";
    logic [N*W-1:0] expq [$];

    always #2.5 bclk = ~bclk;

    lvds_serial_deser #(.N_CH(N)) uut (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .frame_in   (frame_in),
        .lane_a     (lane_a),
        .lane_b     (lane_b),
        .two_wire   (two_wire),
        .res_sel    (res_sel),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Word monitor, sampled 1 ns after each rising edge.
    always @(posedge bclk) begin
        #1;
        if (rst_n && word_valid) begin
            nvalid++;
            if (expq.size() == 0) begin
                check(1'b0, cur_req, "unexpected word", word_out, '0);
            end else begin
                logic [N*W-1:0] e;
                e = expq.pop_front();
                check(word_out == e, cur_req, "word", word_out, e);
            end
        end
    end

    task automatic drive_edge(input logic [N-1:0] a, input logic [N-1:0] b, input logic f);
        @(bclk);
        #1;
        lane_a   = a;
        lane_b   = b;
        frame_in = f;
    endtask

    task automatic idle(input int n, input logic f);
        for (int k = 0; k < n; k++) begin
            drive_edge(N'($urandom), N'($urandom), f);
        end
    endtask

    function automatic logic [N*W-1:0] rand_samples(input int res);
        logic [N*W-1:0] s;
        for (int c = 0; c < N; c++) begin
            s[c*W +: W] = W'($urandom) & W'((32'h1 << res) - 1);
        end
        return s;
    endfunction

    // Serialize one frame; stop_at limits the number of edges sent.
    task automatic send_frame(input bit tw, input int res, input logic [N*W-1:0] s,
                              input bit expect_it, input int stop_at);
        int bl;
        bl = tw ? res / 2 : res;
        if (expect_it) expq.push_back(s);
        for (int j = 0; j < bl && j < stop_at; j++) begin
            logic [N-1:0] a, b;
            for (int c = 0; c < N; c++) begin
                if (tw) begin
                    a[c] = s[c*W + 2*(bl-1-j)];
                    b[c] = s[c*W + 2*(bl-1-j) + 1];
                end else begin
                    a[c] = s[c*W + res-1-j];
                    b[c] = 1'($urandom);
                end
            end
            drive_edge(a, b, (j < (bl + 1) / 2));
        end
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", nvalid, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        // R6: reset state
        lane_a = N'($urandom);
        lane_b = N'($urandom);
        repeat (4) @(posedge bclk);
        #1;
        cur_req = "R6";
        check(word_valid == 1'b0, "R6", "valid in reset", {63'b0, word_valid}, '0);
        check(word_out == '0, "R6", "words in reset", word_out, '0);
        rst_n = 1'b1;

        // R6/R4: frame high at release, then garbage with frame low: no words
        idle(10, 1'b1);
        idle(7, 1'b0);
        check(nvalid == 0, "R6", "words before first boundary", N*W'(nvalid), '0);

        // Table walk: R1 R2 R3 R5 R8
        for (int t = 0; t < NT; t++) begin
            logic tw;
            int   res;
            tw  = CFG_TBL[t][7];
            res = int'(CFG_TBL[t][4:0]);
            cur_req = tw ? "R2 R3 R5" : "R1 R3 R5 R8";
            drive_edge(N'($urandom), N'($urandom), 1'b0);
            two_wire = tw;
            res_sel  = CFG_TBL[t][6:5];
            idle(8, 1'b0);
            base = nvalid;
            for (int f = 0; f < NF; f++) begin
                send_frame(tw, res, rand_samples(res), 1'b1, 99);
            end
            idle(8, 1'b0);
            check(nvalid - base == NF, "R5", "words per frames", N*W'(nvalid - base), N*W'(NF));
            check(expq.size() == 0, "R5", "pending words", N*W'(expq.size()), '0);
        end

        // R7: early boundary discards a partial word
        cur_req = "R7";
        drive_edge('0, '0, 1'b0);
        two_wire = 1'b0;
        res_sel  = 2'd0;
        idle(8, 1'b0);
        base = nvalid;
        send_frame(1'b0, 12, rand_samples(12), 1'b0, 5);
        idle(2, 1'b0);
        send_frame(1'b0, 12, rand_samples(12), 1'b1, 99);
        idle(8, 1'b0);
        check(nvalid - base == 1, "R7", "words after early boundary", N*W'(nvalid - base), N*W'(1));
        check(expq.size() == 0, "R7", "pending words", N*W'(expq.size()), '0);

        // R9: configuration change mid-frame abandons the word
        cur_req = "R9";
        base = nvalid;
        send_frame(1'b0, 12, rand_samples(12), 1'b0, 4);
        two_wire = 1'b1;
        res_sel  = 2'd2;
        idle(14, 1'b0);
        check(nvalid - base == 0, "R9", "words after reconfigure", N*W'(nvalid - base), '0);
        send_frame(1'b1, 16, rand_samples(16), 1'b1, 99);
        send_frame(1'b1, 16, rand_samples(16), 1'b1, 99);
        idle(8, 1'b0);
        check(nvalid - base == 2, "R9", "words after new boundary", N*W'(nvalid - base), N*W'(2));
        check(expq.size() == 0, "R9", "pending words", N*W'(expq.size()), '0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule